// File: doc/BRIEF.md
# Selectable-Protocol Line Coherency Controller

This block decides the coherency state of one line of a write-back data cache. Each cycle it takes one event: a local processor access, a local cache-maintenance operation, or a transaction snooped from the system bus. It also takes the current state of the addressed line. One cycle later it returns the line's next state, the snoop response (address retry, shared, data intervention), a write-back request, and, when needed, a request to broadcast a maintenance operation on the system bus. Tag and data arrays, bus wiring and victim selection sit outside the block.

Three protocols are selectable at run time. The five-state protocol (Modified, Exclusive, Reserved, Shared, Invalid) is active when intervention is enabled and the bus mode can carry intervention. In that protocol a snooped read is served from this cache, and the Reserved state marks the clean copy that supplies data. Otherwise a single configuration bit chooses four-state MESI or three-state MEI. In MEI the Shared state never appears.

State encoding on `line_state` and `o_next_state`: Invalid=0, Shared=1, Exclusive=2, Reserved=3, Modified=4. Local operation codes on `loc_op`: load=0, store=1, clean=2, flush=3, data invalidate=4, instruction invalidate=5. Snoop codes on `snp_op`: read=0, read-with-intent-to-modify=1, kill=2, clean=3, flush=4, data invalidate=5. Broadcast kinds on `o_bc_kind`: kill=0, clean=1, flush=2, data invalidate=3, instruction invalidate=4, read-with-intent-to-modify=5. The value 0 means no broadcast when `o_bc_req` is low.

Top module: `coh_ctrl`

## Requirements
- R1: While `rst_n` is low, `o_valid`, `o_retry`, `o_shared`, `o_intv`, `o_wb_req` and `o_bc_req` are 0, and `o_bc_kind` and `o_next_state` are 0 (Invalid).
- R2: The five-state protocol is active exactly when `cfg_intv_en` and `cfg_intv_bus` are both 1. Otherwise `cfg_shared_en`=1 selects MESI and 0 selects MEI. Outside the five-state protocol, an incoming Reserved line is treated as Exclusive. Line codes 5 to 7 are treated as Invalid.
- R3: Five-state protocol, global snooped read hitting Exclusive, Reserved or Modified: `o_intv` and `o_shared` are 1 and the next state is Reserved. A Modified line also raises `o_wb_req`.
- R4: Outside the five-state protocol, a global snooped read hitting Modified raises `o_retry` and `o_wb_req`. The next state is Shared under MESI and Invalid under MEI.
- R5: Under MEI, Shared never appears as a next state, and an incoming Shared line is treated as Invalid. A load miss fills as Exclusive, and a snooped read hitting Exclusive gives Invalid with no shared response.
- R6: Under MESI and the five-state protocol, a load miss fills as Shared when `fill_shared` is 1 and as Exclusive otherwise. Under MESI, a snooped read hitting Exclusive or Shared gives Shared with `o_shared`=1.
- R7: A local store moves the line to Modified. A hit on Exclusive, Reserved or Modified broadcasts nothing. A hit on Shared broadcasts a kill. A miss broadcasts read-with-intent-to-modify.
- R8: Local clean, flush and data invalidate are broadcast only when `loc_coh` is 1. Clean of Modified gives Exclusive with a write-back. Flush gives Invalid, with a write-back if the line was Modified. Data invalidate gives Invalid with no write-back.
- R9: A local instruction invalidate is always broadcast, whatever `loc_coh` is, and leaves the line state unchanged.
- R10: A global snooped kill, read-with-intent-to-modify, flush or data invalidate gives Invalid, with `o_wb_req` if the line was Modified. A global snooped clean turns Modified into Exclusive with a write-back and leaves other states unchanged.
- R11: A snoop with `snp_global`=0 is ignored: it gives no response, and the result is that of the local event in the same cycle, or the unchanged line state if there is none.
- R12: When a global snoop and a local event arrive in the same cycle, the snoop is processed and the local event is dropped.
- R13: Outputs appear one clock after the event is sampled. `o_valid` is 1 only after a cycle with `loc_valid` or `snp_valid`. After an idle cycle all flags are 0 and `o_next_state` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_intv_bus | input | 1 | Bus mode can carry intervention |
| cfg_intv_en | input | 1 | Intervention enabled |
| cfg_shared_en | input | 1 | 1 = MESI, 0 = MEI when five-state is off |
| line_state | input | 3 | Current state of addressed line |
| fill_shared | input | 1 | Another cache reported a copy on the fill |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 3 | Local operation code |
| loc_coh | input | 1 | Coherency-required page attribute |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 3 | Snooped operation code |
| snp_global | input | 1 | Snooped transaction is marked global |
| o_valid | output | 1 | Result valid |
| o_next_state | output | 3 | Next line state |
| o_retry | output | 1 | Address retry response |
| o_shared | output | 1 | Shared response |
| o_intv | output | 1 | Data intervention response |
| o_wb_req | output | 1 | Write back the line |
| o_bc_req | output | 1 | Broadcast request |
| o_bc_kind | output | 3 | Broadcast kind |

## Verification
A wrong protocol selection or a wrong state normalization shows on the very next clock. It appears as a Reserved or Shared next state in a protocol that forbids it, as a retry where intervention was due, or the reverse. Every event produces its full result one cycle after it is sampled, and the block keeps no hidden history beyond the held next state. So any fault in a transition, a response or a broadcast decision differs from the bench's cycle model at that one sample. Random mixes of configuration, line state and simultaneous local and snoop events reach every transition, including the collision and non-global cases, thousands of times.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int ST_W = 3;
  localparam int OP_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_INV = 3'd0,
    ST_SHR = 3'd1,
    ST_EXC = 3'd2,
    ST_RSV = 3'd3,
    ST_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    MD_MEI   = 2'd0,
    MD_MESI  = 2'd1,
    MD_MERSI = 2'd2
  } proto_e;

  // local operation codes
  localparam logic [OP_W-1:0] LO_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] LO_STORE = 3'd1;
  localparam logic [OP_W-1:0] LO_CLEAN = 3'd2;
  localparam logic [OP_W-1:0] LO_FLUSH = 3'd3;
  localparam logic [OP_W-1:0] LO_DINV  = 3'd4;
  localparam logic [OP_W-1:0] LO_IINV  = 3'd5;

  // snooped operation codes
  localparam logic [OP_W-1:0] SN_READ  = 3'd0;
  localparam logic [OP_W-1:0] SN_RWITM = 3'd1;
  localparam logic [OP_W-1:0] SN_KILL  = 3'd2;
  localparam logic [OP_W-1:0] SN_CLEAN = 3'd3;
  localparam logic [OP_W-1:0] SN_FLUSH = 3'd4;
  localparam logic [OP_W-1:0] SN_DINV  = 3'd5;

  // broadcast kinds
  localparam logic [OP_W-1:0] BC_KILL  = 3'd0;
  localparam logic [OP_W-1:0] BC_CLEAN = 3'd1;
  localparam logic [OP_W-1:0] BC_FLUSH = 3'd2;
  localparam logic [OP_W-1:0] BC_DINV  = 3'd3;
  localparam logic [OP_W-1:0] BC_IINV  = 3'd4;
  localparam logic [OP_W-1:0] BC_RWITM = 3'd5;

  typedef struct packed {
    line_st_e        nxt;
    logic            retry;
    logic            shared;
    logic            intv;
    logic            wb;
    logic            bc;
    logic [OP_W-1:0] kind;
  } coh_res_t;
endpackage

// File: rtl/coh_mode_dec.sv
module coh_mode_dec
  import coh_pkg::*;
(
  input  logic            intv_bus,
  input  logic            intv_en,
  input  logic            shared_en,
  input  logic [ST_W-1:0] raw_state,
  output proto_e          mode,
  output line_st_e        st
);
  always_comb begin
    if (intv_en && intv_bus)  mode = MD_MERSI;
    else if (shared_en)       mode = MD_MESI;
    else                      mode = MD_MEI;
  end

  // fold states the active protocol cannot hold
  always_comb begin
    case (raw_state)
      3'd1:    st = (mode == MD_MEI) ? ST_INV : ST_SHR;
      3'd2:    st = ST_EXC;
      3'd3:    st = (mode == MD_MERSI) ? ST_RSV : ST_EXC;
      3'd4:    st = ST_MOD;
      default: st = ST_INV;
    endcase
  end
endmodule

// File: rtl/coh_local_fsm.sv
module coh_local_fsm
  import coh_pkg::*;
(
  input  proto_e          mode,
  input  line_st_e        st,
  input  logic [OP_W-1:0] op,
  input  logic            coh,
  input  logic            fill_shared,
  output coh_res_t        res
);
  always_comb begin
    res     = '0;
    res.nxt = st;
    case (op)
      LO_LOAD: begin
        if (st == ST_INV)
          res.nxt = (mode == MD_MEI || !fill_shared) ? ST_EXC : ST_SHR;
      end
      LO_STORE: begin
        res.nxt = ST_MOD;
        if (st == ST_INV) begin
          res.bc   = 1'b1;
          res.kind = BC_RWITM;
        end else if (st == ST_SHR) begin
          res.bc   = 1'b1;
          res.kind = BC_KILL;
        end
      end
      LO_CLEAN: begin
        if (st == ST_MOD) begin
          res.nxt = ST_EXC;
          res.wb  = 1'b1;
        end
        res.bc   = coh;
        res.kind = coh ? BC_CLEAN : '0;
      end
      LO_FLUSH: begin
        res.nxt  = ST_INV;
        res.wb   = (st == ST_MOD);
        res.bc   = coh;
        res.kind = coh ? BC_FLUSH : '0;
      end
      LO_DINV: begin
        res.nxt  = ST_INV;
        res.bc   = coh;
        res.kind = coh ? BC_DINV : '0;
      end
      LO_IINV: begin
        res.bc   = 1'b1;
        res.kind = BC_IINV;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  proto_e          mode,
  input  line_st_e        st,
  input  logic [OP_W-1:0] op,
  output coh_res_t        res
);
  always_comb begin
    res     = '0;
    res.nxt = st;
    case (op)
      SN_READ: begin
        case (st)
          ST_SHR: res.shared = 1'b1;
          ST_EXC, ST_RSV: begin
            if (mode == MD_MERSI) begin
              res.nxt    = ST_RSV;
              res.intv   = 1'b1;
              res.shared = 1'b1;
            end else if (mode == MD_MESI) begin
              res.nxt    = ST_SHR;
              res.shared = 1'b1;
            end else begin
              res.nxt    = ST_INV;
            end
          end
          ST_MOD: begin
            res.wb = 1'b1;
            if (mode == MD_MERSI) begin
              res.nxt    = ST_RSV;
              res.intv   = 1'b1;
              res.shared = 1'b1;
            end else begin
              res.retry  = 1'b1;
              res.nxt    = (mode == MD_MESI) ? ST_SHR : ST_INV;
            end
          end
          default: ;
        endcase
      end
      SN_RWITM, SN_KILL, SN_FLUSH, SN_DINV: begin
        res.nxt = ST_INV;
        res.wb  = (st == ST_MOD);
      end
      SN_CLEAN: begin
        if (st == ST_MOD) begin
          res.nxt = ST_EXC;
          res.wb  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_intv_bus,
  input  logic            cfg_intv_en,
  input  logic            cfg_shared_en,
  input  logic [ST_W-1:0] line_state,
  input  logic            fill_shared,
  input  logic            loc_valid,
  input  logic [OP_W-1:0] loc_op,
  input  logic            loc_coh,
  input  logic            snp_valid,
  input  logic [OP_W-1:0] snp_op,
  input  logic            snp_global,
  output logic            o_valid,
  output logic [ST_W-1:0] o_next_state,
  output logic            o_retry,
  output logic            o_shared,
  output logic            o_intv,
  output logic            o_wb_req,
  output logic            o_bc_req,
  output logic [OP_W-1:0] o_bc_kind
);
  proto_e   mode;
  line_st_e st;
  coh_res_t loc_res, snp_res, sel_res;
  logic     ev_any, take_snp;

  coh_mode_dec u_dec (
    .intv_bus  (cfg_intv_bus),
    .intv_en   (cfg_intv_en),
    .shared_en (cfg_shared_en),
    .raw_state (line_state),
    .mode      (mode),
    .st        (st)
  );

  coh_local_fsm u_loc (
    .mode        (mode),
    .st          (st),
    .op          (loc_op),
    .coh         (loc_coh),
    .fill_shared (fill_shared),
    .res         (loc_res)
  );

  coh_snoop_fsm u_snp (
    .mode (mode),
    .st   (st),
    .op   (snp_op),
    .res  (snp_res)
  );

  // arbitration: a global snoop wins over the local event
  always_comb begin
    ev_any   = loc_valid | snp_valid;
    take_snp = snp_valid & snp_global;
    sel_res  = '0;
    sel_res.nxt = st;
    if (take_snp)       sel_res = snp_res;
    else if (loc_valid) sel_res = loc_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid   <= 1'b0;
      o_retry   <= 1'b0;
      o_shared  <= 1'b0;
      o_intv    <= 1'b0;
      o_wb_req  <= 1'b0;
      o_bc_req  <= 1'b0;
      o_bc_kind <= '0;
    end else begin
      o_valid   <= ev_any;
      o_retry   <= ev_any & sel_res.retry;
      o_shared  <= ev_any & sel_res.shared;
      o_intv    <= ev_any & sel_res.intv;
      o_wb_req  <= ev_any & sel_res.wb;
      o_bc_req  <= ev_any & sel_res.bc;
      o_bc_kind <= (ev_any & sel_res.bc) ? sel_res.kind : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      o_next_state <= ST_INV;
    else if (ev_any) o_next_state <= sel_res.nxt;
  end

  AST_MEI_NO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(mode) == MD_MEI) |-> o_next_state != ST_SHR); // R5

  AST_RSV_FIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(mode) != MD_MERSI) |-> o_next_state != ST_RSV); // R2

  AST_INTV_FIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    o_intv |-> ($past(mode) == MD_MERSI && o_shared && !o_retry)); // R3

  AST_RETRY_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    o_retry |-> (o_wb_req && $past(mode) != MD_MERSI)); // R4

  AST_IINV_ALWAYS_BC: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !(snp_valid && snp_global) && loc_op == LO_IINV)
      |=> (o_bc_req && o_bc_kind == BC_IINV)); // R9

  AST_SNP_KILL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_global && (snp_op == SN_KILL || snp_op == SN_DINV))
      |=> o_next_state == ST_INV); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> !(o_retry || o_shared || o_intv || o_wb_req || o_bc_req)); // R13

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_valid && !snp_valid) |=> $stable(o_next_state)); // R13
endmodule

// File: tb/test_coh_ctrl.sv
module test_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_CYCLES   = 4000;
  localparam int WATCHDOG   = 20000;

  logic       clk, rst_n;
  logic       cfg_intv_bus, cfg_intv_en, cfg_shared_en;
  logic [2:0] line_state;
  logic       fill_shared;
  logic       loc_valid, loc_coh;
  logic [2:0] loc_op;
  logic       snp_valid, snp_global;
  logic [2:0] snp_op;
  logic       o_valid, o_retry, o_shared, o_intv, o_wb_req, o_bc_req;
  logic [2:0] o_next_state, o_bc_kind;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // expected outputs
  int    e_valid, e_state, e_retry, e_shared, e_intv, e_wb, e_bc, e_kind;
  string e_tag;

  coh_ctrl i_coh_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_intv_bus(cfg_intv_bus), .cfg_intv_en(cfg_intv_en),
    .cfg_shared_en(cfg_shared_en), .line_state(line_state),
    .fill_shared(fill_shared), .loc_valid(loc_valid), .loc_op(loc_op),
    .loc_coh(loc_coh), .snp_valid(snp_valid), .snp_op(snp_op),
    .snp_global(snp_global), .o_valid(o_valid), .o_next_state(o_next_state),
    .o_retry(o_retry), .o_shared(o_shared), .o_intv(o_intv),
    .o_wb_req(o_wb_req), .o_bc_req(o_bc_req), .o_bc_kind(o_bc_kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model of one event, from the requirements
  task automatic model();
    int m, s;
    bit snp_take;
    m = (cfg_intv_en && cfg_intv_bus) ? 2 : (cfg_shared_en ? 1 : 0);
    s = int'(line_state);
    e_tag = "R13";
    if (s > 4) begin s = 0; e_tag = "R2"; end
    if (s == 3 && m != 2) begin s = 2; e_tag = "R2"; end
    if (s == 1 && m == 0) begin s = 0; e_tag = "R5"; end
    e_retry = 0; e_shared = 0; e_intv = 0; e_wb = 0; e_bc = 0; e_kind = 0;
    e_valid = (loc_valid || snp_valid) ? 1 : 0;
    if (!e_valid) return;
    e_state  = s;
    snp_take = snp_valid && snp_global;
    if (snp_take) begin
      e_tag = loc_valid ? "R12" : "R10";
      if (snp_op == 3'd0) begin
        if (m == 2 && (s == 2 || s == 3 || s == 4)) begin
          e_tag = "R3"; e_state = 3; e_intv = 1; e_shared = 1; e_wb = (s == 4);
        end else if (s == 4) begin
          e_tag = "R4"; e_retry = 1; e_wb = 1; e_state = (m == 1) ? 1 : 0;
        end else if (s == 2 && m == 0) begin
          e_tag = "R5"; e_state = 0;
        end else if (s == 2 || s == 1) begin
          e_tag = "R6"; e_state = 1; e_shared = 1;
        end
      end else if (snp_op == 3'd3) begin
        if (s == 4) begin e_state = 2; e_wb = 1; end
      end else if (snp_op <= 3'd5) begin
        e_wb = (s == 4); e_state = 0;
      end
    end else if (loc_valid) begin
      if (snp_valid) e_tag = "R11";
      case (loc_op)
        3'd0: if (s == 0) begin
          e_tag = (m == 0) ? "R5" : "R6";
          e_state = (m == 0 || !fill_shared) ? 2 : 1;
        end
        3'd1: begin
          e_tag = "R7"; e_state = 4;
          if (s == 0) begin e_bc = 1; e_kind = 5; end
          if (s == 1) begin e_bc = 1; e_kind = 0; end
        end
        3'd2: begin
          e_tag = "R8";
          if (s == 4) begin e_state = 2; e_wb = 1; end
          if (loc_coh) begin e_bc = 1; e_kind = 1; end
        end
        3'd3: begin
          e_tag = "R8"; e_state = 0; e_wb = (s == 4);
          if (loc_coh) begin e_bc = 1; e_kind = 2; end
        end
        3'd4: begin
          e_tag = "R8"; e_state = 0;
          if (loc_coh) begin e_bc = 1; e_kind = 3; end
        end
        3'd5: begin e_tag = "R9"; e_bc = 1; e_kind = 4; end
        default: ;
      endcase
    end else begin
      e_tag = "R11";
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(o_valid) != e_valid || int'(o_next_state) != e_state ||
        int'(o_retry) != e_retry || int'(o_shared) != e_shared ||
        int'(o_intv) != e_intv || int'(o_wb_req) != e_wb ||
        int'(o_bc_req) != e_bc || int'(o_bc_kind) != e_kind) begin
      errors++;
      $display("FAIL %s actual v=%0d st=%0d rt=%0d sh=%0d iv=%0d wb=%0d bc=%0d k=%0d expected v=%0d st=%0d rt=%0d sh=%0d iv=%0d wb=%0d bc=%0d k=%0d",
        tag, o_valid, o_next_state, o_retry, o_shared, o_intv, o_wb_req,
        o_bc_req, o_bc_kind, e_valid, e_state, e_retry, e_shared, e_intv,
        e_wb, e_bc, e_kind);
    end
  endtask

  task automatic drive_random();
    cfg_intv_bus  = 1'($urandom);
    cfg_intv_en   = 1'($urandom);
    cfg_shared_en = 1'($urandom);
    line_state    = 3'($urandom % 8);
    fill_shared   = 1'($urandom);
    loc_valid     = ($urandom % 3) != 0;
    loc_op        = 3'($urandom % 6);
    loc_coh       = 1'($urandom);
    snp_valid     = ($urandom % 2) != 0;
    snp_op        = 3'($urandom % 6);
    snp_global    = ($urandom % 4) != 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_intv_bus = 0; cfg_intv_en = 0; cfg_shared_en = 0;
    line_state = 0; fill_shared = 0; loc_valid = 0; loc_op = 0;
    loc_coh = 0; snp_valid = 0; snp_op = 0; snp_global = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    e_valid = 0; e_state = 0; e_retry = 0; e_shared = 0; e_intv = 0;
    e_wb = 0; e_bc = 0; e_kind = 0;
    compare("R1");
    rst_n = 1'b1;
    // R9 with coherency attribute clear, in a quiet cycle
    loc_valid = 1; loc_op = 3'd5; loc_coh = 0; line_state = 3'd4;
    model();
    for (int i = 0; i < N_CYCLES; i++) begin
      @(negedge clk);
      compare(e_tag);
      if (i % 17 == 5) begin
        // idle cycle: flags drop, state held (R13)
        loc_valid = 0; snp_valid = 0;
      end else begin
        drive_random();
      end
      model();
    end
    @(negedge clk);
    compare(e_tag);
    done = 1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule